// File: doc/BRIEF.md
# Power State and Wake Controller

This block sequences a network controller between its full-power state D0 and two sleep states, D1 and D2. The host reaches it through a single-cycle register port. A control register selects the power mode and holds the wake configuration. An interrupt-status register holds the wake interrupt flag. A fixed-pattern test register doubles as the doorbell that brings the device out of sleep. The block drives one clock-enable line per internal clock domain, a power-management-event output (`pme_o`) and an interrupt line.

A ready flag gates host access. The flag is clear while sleeping and for a fixed number of cycles after clocks come back. While it is clear, only the control register can be read, and the only write with any effect is a write to the test register from a sleep state. Each time the device leaves reset or wakes up, host writes stay disabled until the host has made at least one accepted read. Wake-event pulses from the frame detectors are honoured only in D1.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the mode is D0, every clock enable is 1, and `pme_o` and `irq_o` are 0. The ready flag is 0 and becomes 1 on the `WAKE_DLY`-th rising clock edge after reset is released.
- R2: A host write has no effect until a read has been accepted since the last reset or the last wake-up write.
- R3: The control register (`CTRL_ADDR`, default 0) has this layout: bits [1:0] mode (00 D0, 01 D1, 10 D2), bit 2 ready (read-only), bit 3 wake enable, bit 4 PME enable, bits [6:5] wake status, bit 7 interrupt enable. Writing mode 01 enters D1 and clears ready on the same edge. In D1 only the domains set in `D1_KEEP` keep their enable (default 3'b011).
- R4: Writing mode 10 enters D2, which drops every clock enable. Writing 00 or 11 leaves the mode unchanged.
- R5: While ready is 0, a read of any address other than the control register is answered with `rd_blocked_o`=1 and data 0. A read of the control register returns its contents.
- R6: While ready is 0, every write is ignored, except a write to the test register made from D1 or D2.
- R7: A write of any value to the test register (`TEST_ADDR`, default 2) from D1 or D2 returns the block to D0 on that edge, with all clocks enabled and mode reading 00. Ready returns `WAKE_DLY` edges later.
- R8: A wake pulse in D1 sets wake status to 10b and sets the interrupt-status flag (bit 0 of `INT_ADDR`, default 1). `pme_o` rises only if both wake enable and PME enable are 1.
- R9: Wake pulses in D0 or D2 change neither status nor outputs.
- R10: `irq_o` is high exactly while the interrupt-status flag and interrupt enable are both 1.
- R11: Writing 1 to a wake-status bit or to the interrupt-status bit clears it. Clearing wake-status bit 6 also drops `pme_o`.
- R12: A read returns its result with `rd_valid_o` one cycle after the request. An accepted read of the test register returns `TEST_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_rd_i | input | 1 | Single-cycle read request |
| host_wr_i | input | 1 | Single-cycle write request |
| host_addr_i | input | ADDR_W | Register address |
| host_wdata_i | input | DATA_W | Write data |
| wake_ev_i | input | 1 | Wake-frame or magic-packet detection pulse |
| rd_valid_o | output | 1 | Read response valid |
| rd_blocked_o | output | 1 | Read was refused by the access lockout |
| rd_data_o | output | DATA_W | Read data, 0 when blocked |
| clk_en_o | output | NUM_DOM | Per-domain clock enable |
| pme_o | output | 1 | Power-management event |
| irq_o | output | 1 | Host interrupt |

## Verification
Wake pulses are sent in all three modes and under different enable settings. The D0 and D2 pulses must leave everything untouched. The D1 pulses separate the status and interrupt path, which ignores the PME enable, from `pme_o`, which needs both enables. Writes are tried without a prior read, during the post-wake delay, and while asleep. Each such write is followed by a read-back that tells a write dropped by the lockout from one dropped because no read had yet been made. Reads of every register in each mode show the blocked and accepted responses, and a reset applied mid-run confirms that ready starts out clear.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PM_D0 = 2'b00,
    PM_D1 = 2'b01,
    PM_D2 = 2'b10
  } pm_mode_e;

  localparam int CF_MODE_LSB = 0;
  localparam int CF_READY    = 2;
  localparam int CF_WEN      = 3;
  localparam int CF_PEN      = 4;
  localparam int CF_WSTS_LSB = 5;
  localparam int CF_IEN      = 7;
  localparam int CF_W        = 8;

  localparam logic [1:0] WSTS_FRAME = 2'b10;
endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm import pwr_pkg::*; #(
  parameter int WAKE_DLY = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_mode_i,
  input  logic [1:0] new_mode_i,
  input  logic       wake_req_i,
  output pm_mode_e   mode_o,
  output logic       ready_o
);
  localparam int CNT_W = $clog2(WAKE_DLY + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= PM_D0;
      ready_o <= 1'b0;
      cnt_q   <= CNT_W'(WAKE_DLY);
    end else if (wake_req_i && mode_o != PM_D0) begin
      mode_o  <= PM_D0;
      ready_o <= 1'b0;
      cnt_q   <= CNT_W'(WAKE_DLY);
    end else if (set_mode_i && new_mode_i == PM_D1) begin
      mode_o  <= PM_D1;
      ready_o <= 1'b0;
    end else if (set_mode_i && new_mode_i == PM_D2) begin
      mode_o  <= PM_D2;
      ready_o <= 1'b0;
    end else if (cnt_q != '0) begin
      // clock re-enable settling window
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) ready_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_access.sv
module pwr_access #(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] TEST_ADDR = ADDR_W'(2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ready_i,
  input  logic              low_pwr_i,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic              wake_req_o
);
  logic armed_q;

  assign rd_ok_o    = rd_i && (ready_i || addr_i == CTRL_ADDR);
  assign wr_ok_o    = wr_i && ready_i && armed_q;
  assign wake_req_o = wr_i && low_pwr_i && addr_i == TEST_ADDR;

  // writes stay disabled until a read lands after reset or wake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (wake_req_o) armed_q <= 1'b0;
    else if (rd_ok_o)    armed_q <= 1'b1;
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl import pwr_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wake_ev_i,
  input  logic       in_d1_i,
  input  logic       wake_en_i,
  input  logic       pme_en_i,
  input  logic       irq_en_i,
  input  logic [1:0] clr_sts_i,
  input  logic       clr_int_i,
  output logic [1:0] wake_sts_o,
  output logic       pme_int_o,
  output logic       pme_o,
  output logic       irq_o
);
  logic hit;

  assign hit   = wake_ev_i && in_d1_i;
  assign irq_o = pme_int_o && irq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_sts_o <= '0;
      pme_int_o  <= 1'b0;
      pme_o      <= 1'b0;
    end else if (hit) begin
      wake_sts_o <= WSTS_FRAME;
      pme_int_o  <= 1'b1;
      if (wake_en_i && pme_en_i) pme_o <= 1'b1;
    end else begin
      wake_sts_o <= wake_sts_o & ~clr_sts_i;
      if (clr_int_i)    pme_int_o <= 1'b0;
      if (clr_sts_i[1]) pme_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_clk_map.sv
module pwr_clk_map import pwr_pkg::*; #(
  parameter int                 NUM_DOM = 3,
  parameter logic [NUM_DOM-1:0] D1_KEEP = NUM_DOM'(3)
) (
  input  pm_mode_e           mode_i,
  output logic [NUM_DOM-1:0] clk_en_o
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign clk_en_o[d] = (mode_i == PM_D0) || (mode_i == PM_D1 && D1_KEEP[d]);
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl import pwr_pkg::*; #(
  parameter int                 ADDR_W    = 4,
  parameter int                 DATA_W    = 32,
  parameter int                 NUM_DOM   = 3,
  parameter int                 WAKE_DLY  = 8,
  parameter logic [NUM_DOM-1:0] D1_KEEP   = NUM_DOM'(3),
  parameter logic [ADDR_W-1:0]  CTRL_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0]  INT_ADDR  = ADDR_W'(1),
  parameter logic [ADDR_W-1:0]  TEST_ADDR = ADDR_W'(2),
  parameter logic [DATA_W-1:0]  TEST_VAL  = DATA_W'(32'h3C5A_A5C3)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_rd_i,
  input  logic               host_wr_i,
  input  logic [ADDR_W-1:0]  host_addr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  input  logic               wake_ev_i,
  output logic               rd_valid_o,
  output logic               rd_blocked_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [NUM_DOM-1:0] clk_en_o,
  output logic               pme_o,
  output logic               irq_o
);
  pm_mode_e    mode_q;
  logic        ready_q;
  logic        low_pwr;
  logic        rd_ok, wr_ok, wake_req;
  logic        ctrl_hit, int_hit, test_hit, cfg_wr;
  logic        wake_en_q, pme_en_q, irq_en_q;
  logic [1:0]  wake_sts;
  logic        pme_int;
  logic [1:0]  clr_sts;
  logic        clr_int;
  logic [CF_W-1:0]   ctrl_word;
  logic [DATA_W-1:0] rd_word;

  assign low_pwr  = mode_q != PM_D0;
  assign ctrl_hit = host_addr_i == CTRL_ADDR;
  assign int_hit  = host_addr_i == INT_ADDR;
  assign test_hit = host_addr_i == TEST_ADDR;
  assign cfg_wr   = wr_ok && ctrl_hit;

  pwr_access #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .TEST_ADDR(TEST_ADDR)
  ) u_acc (
    .clk_i, .rst_ni,
    .rd_i(host_rd_i), .wr_i(host_wr_i), .addr_i(host_addr_i),
    .ready_i(ready_q), .low_pwr_i(low_pwr),
    .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .wake_req_o(wake_req)
  );

  pwr_mode_fsm #(.WAKE_DLY(WAKE_DLY)) u_fsm (
    .clk_i, .rst_ni,
    .set_mode_i(cfg_wr),
    .new_mode_i(host_wdata_i[CF_MODE_LSB +: 2]),
    .wake_req_i(wake_req),
    .mode_o(mode_q), .ready_o(ready_q)
  );

  pwr_clk_map #(.NUM_DOM(NUM_DOM), .D1_KEEP(D1_KEEP)) u_clk (
    .mode_i(mode_q), .clk_en_o(clk_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_en_q <= 1'b0;
      pme_en_q  <= 1'b0;
      irq_en_q  <= 1'b0;
    end else if (cfg_wr) begin
      wake_en_q <= host_wdata_i[CF_WEN];
      pme_en_q  <= host_wdata_i[CF_PEN];
      irq_en_q  <= host_wdata_i[CF_IEN];
    end
  end

  assign clr_sts = cfg_wr ? host_wdata_i[CF_WSTS_LSB +: 2] : 2'b00;
  assign clr_int = wr_ok && int_hit && host_wdata_i[0];

  pwr_wake_ctrl u_wake (
    .clk_i, .rst_ni,
    .wake_ev_i, .in_d1_i(mode_q == PM_D1),
    .wake_en_i(wake_en_q), .pme_en_i(pme_en_q), .irq_en_i(irq_en_q),
    .clr_sts_i(clr_sts), .clr_int_i(clr_int),
    .wake_sts_o(wake_sts), .pme_int_o(pme_int),
    .pme_o(pme_o), .irq_o(irq_o)
  );

  assign ctrl_word = {irq_en_q, wake_sts, pme_en_q, wake_en_q, ready_q, mode_q};

  always_comb begin
    rd_word = '0;
    if (ctrl_hit)      rd_word = DATA_W'(ctrl_word);
    else if (int_hit)  rd_word = DATA_W'(pme_int);
    else if (test_hit) rd_word = TEST_VAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o   <= 1'b0;
      rd_blocked_o <= 1'b0;
      rd_data_o    <= '0;
    end else begin
      rd_valid_o   <= host_rd_i;
      rd_blocked_o <= host_rd_i && !rd_ok;
      rd_data_o    <= rd_ok ? rd_word : '0;
    end
  end
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 32,
  parameter int                NUM_DOM   = 3,
  parameter logic [ADDR_W-1:0] TEST_ADDR = ADDR_W'(2)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               host_wr_i,
  input logic [ADDR_W-1:0]  host_addr_i,
  input logic               wake_ev_i,
  input logic               rd_blocked_o,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic [NUM_DOM-1:0] clk_en_o,
  input logic               pme_o,
  input logic [1:0]         mode_i,
  input logic               ready_i,
  input logic               wake_en_i,
  input logic               pme_en_i
);
  a_r5_blocked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_blocked_o |-> rd_data_o == '0);

  a_r3_sleep_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b00) |-> !ready_i);

  a_r7_wake_clocks_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && mode_i != 2'b00 && host_addr_i == TEST_ADDR) |=> (clk_en_o == '1));

  a_r8_pme_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pme_o) |-> $past(wake_en_i && pme_en_i));

  a_r6_locked_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !ready_i) |=> ($stable(wake_en_i) && $stable(pme_en_i)));

  a_r9_d2_no_pme: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_ev_i && mode_i == 2'b10) |=> $stable(pme_o));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DOM(NUM_DOM), .TEST_ADDR(TEST_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .host_wr_i(host_wr_i), .host_addr_i(host_addr_i), .wake_ev_i(wake_ev_i),
  .rd_blocked_o(rd_blocked_o), .rd_data_o(rd_data_o),
  .clk_en_o(clk_en_o), .pme_o(pme_o),
  .mode_i(mode_q), .ready_i(ready_q),
  .wake_en_i(wake_en_q), .pme_en_i(pme_en_q)
);

// File: tb/sim_pwr_state_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctrl;
  localparam int          ADDR_W   = 4;
  localparam int          DATA_W   = 32;
  localparam int          NUM_DOM  = 3;
  localparam int          WAKE_DLY = 8;
  localparam logic [3:0]  A_CTRL   = 4'd0;
  localparam logic [3:0]  A_INT    = 4'd1;
  localparam logic [3:0]  A_TEST   = 4'd2;
  localparam logic [31:0] TVAL     = 32'h3C5A_A5C3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic host_rd = 1'b0, host_wr = 1'b0, wake_ev = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic rd_valid, rd_blocked, pme, irq;
  logic [DATA_W-1:0] rd_data;
  logic [NUM_DOM-1:0] clk_en;

  int n_vec = 0;
  int n_bad = 0;
  logic [DATA_W:0] exp_q[$];
  string           tag_q[$];

  always #2.5 clk = ~clk;

  pwr_state_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_rd_i(host_rd), .host_wr_i(host_wr),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .wake_ev_i(wake_ev),
    .rd_valid_o(rd_valid), .rd_blocked_o(rd_blocked), .rd_data_o(rd_data),
    .clk_en_o(clk_en), .pme_o(pme), .irq_o(irq)
  );

  // monitor: pop expected read responses
  always @(negedge clk) begin
    if (rd_valid) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected read response act=%0b/%h exp=none", rd_blocked, rd_data);
      end else begin
        logic [DATA_W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rd_blocked, rd_data} !== e) begin
          n_bad++;
          $display("FAIL %s read act=%0b/%h exp=%0b/%h", t, rd_blocked, rd_data, e[DATA_W], e[DATA_W-1:0]);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic blk, input logic [31:0] d, input string t);
    exp_q.push_back({blk, d});
    tag_q.push_back(t);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    wake_ev = 1'b1;
    @(negedge clk);
    wake_ev = 1'b0;
  endtask

  task automatic settle();
    repeat (WAKE_DLY + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 clk_en", 32'(clk_en), 32'h7);
    chk("R1 pme", 32'(pme), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2: writes before any read are dropped
    wr(A_CTRL, 32'h18);
    settle();
    wr(A_CTRL, 32'h18);
    rd(A_CTRL, 1'b0, 32'h04, "R2 unarmed write dropped");
    wr(A_CTRL, 32'h98);
    rd(A_CTRL, 1'b0, 32'h9C, "R2 write after read");
    rd(A_TEST, 1'b0, TVAL, "R12 test value");
    rd(A_INT, 1'b0, 32'h0, "R12 int clear");

    // R9: wake pulse in D0 ignored
    pulse();
    chk("R9 D0 pme", 32'(pme), 0);
    chk("R9 D0 irq", 32'(irq), 0);
    rd(A_INT, 1'b0, 32'h0, "R9 D0 int unchanged");

    // R3: enter D1
    wr(A_CTRL, 32'h99);
    chk("R3 D1 clk_en", 32'(clk_en), 32'h3);
    rd(A_CTRL, 1'b0, 32'h99, "R3 D1 ctrl, ready clear");
    rd(A_INT, 1'b1, 32'h0, "R5 int read blocked");
    rd(A_TEST, 1'b1, 32'h0, "R5 test read blocked");

    // R6: writes ignored while asleep
    wr(A_CTRL, 32'h98);
    wr(A_CTRL, 32'h00);
    rd(A_CTRL, 1'b0, 32'h99, "R6 ctrl write ignored");

    // R8/R10: wake pulse in D1
    pulse();
    chk("R8 pme raised", 32'(pme), 1);
    chk("R10 irq raised", 32'(irq), 1);
    rd(A_CTRL, 1'b0, 32'hD9, "R8 wake status 10b");

    // R7: wake via test register
    wr(A_TEST, 32'h0000_1234);
    chk("R7 clocks back", 32'(clk_en), 32'h7);
    rd(A_CTRL, 1'b0, 32'hD8, "R7 mode D0 ready pending");
    settle();
    rd(A_CTRL, 1'b0, 32'hDC, "R7 ready after delay");
    chk("R8 pme held", 32'(pme), 1);

    // R11: write-1-to-clear
    rd(A_INT, 1'b0, 32'h1, "R8 int flag set");
    wr(A_INT, 32'h1);
    rd(A_INT, 1'b0, 32'h0, "R11 int cleared");
    chk("R10 irq drops", 32'(irq), 0);
    wr(A_CTRL, 32'hD8);
    chk("R11 pme drops", 32'(pme), 0);
    rd(A_CTRL, 1'b0, 32'h9C, "R11 wake status cleared");

    // R8: PME enable off, interrupt flag still set
    wr(A_CTRL, 32'h89);
    pulse();
    chk("R8 pme gated", 32'(pme), 0);
    chk("R10 irq without pme_en", 32'(irq), 1);
    wr(A_TEST, 32'h0);
    settle();
    wr(A_INT, 32'h1);
    rd(A_INT, 1'b0, 32'h1, "R2 write dropped after wake");
    wr(A_INT, 32'h1);
    rd(A_INT, 1'b0, 32'h0, "R11 int cleared after read");
    rd(A_CTRL, 1'b0, 32'hCC, "R8 status set without pme_en");
    wr(A_CTRL, 32'hC8);
    rd(A_CTRL, 1'b0, 32'h8C, "R11 status cleared");

    // R4: D2
    wr(A_CTRL, 32'h9A);
    chk("R4 D2 clk_en", 32'(clk_en), 32'h0);
    pulse();
    chk("R9 D2 pme", 32'(pme), 0);
    chk("R9 D2 irq", 32'(irq), 0);
    rd(A_CTRL, 1'b0, 32'h9A, "R4 D2 ctrl");
    wr(A_TEST, 32'hFFFF_FFFF);
    chk("R7 D2 clocks back", 32'(clk_en), 32'h7);
    settle();
    rd(A_CTRL, 1'b0, 32'h9C, "R7 D0 after D2");
    wr(A_CTRL, 32'h9B);
    rd(A_CTRL, 1'b0, 32'h9C, "R4 mode 11 no change");
    chk("R4 mode 11 clk_en", 32'(clk_en), 32'h7);

    // R1: reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    rd(A_CTRL, 1'b0, 32'h00, "R1 ready clear after reset");
    rd(A_INT, 1'b1, 32'h0, "R5 blocked after reset");
    settle();
    rd(A_CTRL, 1'b0, 32'h04, "R1 ready after delay");

    finish_run();
  end
endmodule